// File: doc/BRIEF.md
# Multicycle 16-bit Stored-Program Core

This block is a compact processor core that fetches 16-bit instructions from, and keeps its 16-bit data in, one single-ported word-addressed memory. A program counter, an instruction register, a memory address register and a memory data register sit between the core and that memory. Every memory access first sets the address register. A read then returns its word into the data register one cycle after the read strobe. A write drives the data register out while the write strobe is high.

A phase sequencer moves each instruction through up to six phases: fetch, decode, address evaluation, operand fetch, execute and store. It leaves out the phases an instruction has no use for, so instructions take different numbers of cycles. The core runs register add, AND and NOT, base-plus-offset load and store, and a register-relative jump that can save a return address. A run-enable input freezes the whole core in place, which has the same effect as stopping its clock.

Top module: `mc16_core`

## Requirements
- R1: After reset the register file holds zero and the first cycle is fetch with PC 0, so the first read strobe, one cycle after reset ends, carries address 0.
- R2: Fetch takes three cycles. The first copies PC into the address register, the second raises the read strobe with that address, and the third moves the returned word into the instruction register and sets PC to PC+1.
- R3: Opcode 0001 (bits [15:12]) writes the sum modulo 2^16 of register [8:6] and register [2:0] into register [11:9].
- R4: Opcode 0101 writes the bitwise AND of registers [8:6] and [2:0] into register [11:9]. Opcode 1001 writes the bitwise inverse of register [8:6] into register [11:9].
- R5: Opcode 0110 reads the word at register [8:6] plus the zero-extended bits [5:0] and writes it into register [11:9].
- R6: Opcode 0111 makes one write-strobe cycle at address register [8:6] plus the zero-extended bits [5:0], carrying the contents of register [11:9].
- R7: Opcode 1100 with bit 11 clear loads PC with register [8:6] plus the zero-extended bits [5:0] and changes no register.
- R8: Opcode 1100 with bit 11 set also writes the address of the instruction after the jump into R7.
- R9: Add, AND, NOT, load and store each take 7 cycles including fetch. A jump takes 6.
- R10: Any other opcode takes 4 cycles (fetch and decode only) and changes no register.
- R11: While run enable is low the core keeps all of its state and drives neither strobe. Each cycle spent low delays later activity by exactly one cycle.
- R12: The read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | High lets the sequencer advance; low freezes it |
| mem_addr | output | 16 | Word address, taken from the address register |
| mem_wdata | output | 16 | Write data, taken from the data register |
| mem_rdata | input | 16 | Read data, sampled at the end of a read-strobe cycle |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |

## Verification
The assertions take for granted that run enable is a clean level that is held for whole cycles, and that memory returns a defined word whenever the read strobe is high. The bench drives run enable only at falling edges. Its memory model returns the addressed word combinationally from an array where every word has been written. Each program sweep places its code, data and a self-jump at the end, so the core never fetches from an unwritten or undefined word.

// File: rtl/mc16_pkg.sv
package mc16_pkg;
    localparam int WORD_W  = 16;
    localparam int REG_CNT = 8;
    localparam int RIDX_W  = $clog2(REG_CNT);
    localparam int OFF_W   = 6;
    localparam int OPC_W   = 4;
    localparam int OPC_CNT = 1 << OPC_W;

    localparam logic [OPC_W-1:0] OPC_ADD   = 4'h1;
    localparam logic [OPC_W-1:0] OPC_AND   = 4'h5;
    localparam logic [OPC_W-1:0] OPC_NOT   = 4'h9;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h6;
    localparam logic [OPC_W-1:0] OPC_STORE = 4'h7;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 4'hC;

    localparam logic [RIDX_W-1:0] LINK_REG = RIDX_W'(REG_CNT - 1);

    typedef enum logic [2:0] {
        PH_FETCH, PH_DECODE, PH_EVAL, PH_OPND, PH_EXEC, PH_STORE
    } phase_e;

    typedef enum logic [1:0] { ALU_ADD, ALU_AND, ALU_NOT } alu_op_e;

    typedef struct packed {
        phase_e            phase;
        logic [1:0]        step;
        logic [WORD_W-1:0] pc;
        logic [WORD_W-1:0] ir;
        logic [WORD_W-1:0] mar;
        logic [WORD_W-1:0] mdr;
        logic [WORD_W-1:0] opa;
        logic [WORD_W-1:0] opb;
        logic [WORD_W-1:0] res;
    } core_state_t;
endpackage

// File: rtl/mc16_decode.sv
module mc16_decode #(
    parameter int OPC_W = 4,
    localparam int LINES = 1 << OPC_W
) (
    input  logic [OPC_W-1:0] opc,
    output logic [LINES-1:0] lines
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign lines[i] = (opc == OPC_W'(i));
    end
endmodule

// File: rtl/mc16_alu.sv
module mc16_alu
    import mc16_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        case (op)
            ALU_AND: y = a & b;
            ALU_NOT: y = ~a;
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
    parameter int W = 16,
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ra0,
    input  logic [IW-1:0] ra1,
    input  logic [IW-1:0] ra2,
    output logic [W-1:0]  rd0,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);
    logic [W-1:0] regs_q [N];
    logic [W-1:0] regs_d [N];

    always_comb begin
        regs_d = regs_q;
        if (we) regs_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd0 = regs_q[ra0];
    assign rd1 = regs_q[ra1];
    assign rd2 = regs_q[ra2];
endmodule

// File: rtl/mc16_core.sv
module mc16_core
    import mc16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr
);
    localparam logic [OPC_CNT-1:0] ALU_MASK =
        (OPC_CNT'(1) << OPC_ADD) | (OPC_CNT'(1) << OPC_AND) | (OPC_CNT'(1) << OPC_NOT);
    localparam logic [OPC_CNT-1:0] MEMJ_MASK =
        (OPC_CNT'(1) << OPC_LOAD) | (OPC_CNT'(1) << OPC_STORE) | (OPC_CNT'(1) << OPC_JUMP);

    core_state_t s_q, s_d;

    logic [OPC_CNT-1:0] op_lines;
    logic               is_alu, is_memj, is_ld, is_st, is_jmp, do_link;
    logic [RIDX_W-1:0]  f_dst, f_base, f_src2;
    logic [WORD_W-1:0]  f_off;
    logic [WORD_W-1:0]  rd_base, rd_src2, rd_dst, alu_y;
    alu_op_e            alu_op;
    logic               rf_we;
    logic [RIDX_W-1:0]  rf_waddr;
    logic [WORD_W-1:0]  rf_wdata;

    assign f_dst   = s_q.ir[11:9];
    assign f_base  = s_q.ir[8:6];
    assign f_src2  = s_q.ir[2:0];
    assign f_off   = WORD_W'(s_q.ir[OFF_W-1:0]);
    assign do_link = s_q.ir[11];

    mc16_decode #(.OPC_W(OPC_W)) u_dec (
        .opc   (s_q.ir[WORD_W-1:WORD_W-OPC_W]),
        .lines (op_lines)
    );

    assign is_alu  = |(op_lines & ALU_MASK);
    assign is_memj = |(op_lines & MEMJ_MASK);
    assign is_ld   = op_lines[OPC_LOAD];
    assign is_st   = op_lines[OPC_STORE];
    assign is_jmp  = op_lines[OPC_JUMP];

    always_comb begin
        if (op_lines[OPC_AND])      alu_op = ALU_AND;
        else if (op_lines[OPC_NOT]) alu_op = ALU_NOT;
        else                        alu_op = ALU_ADD;
    end

    mc16_regfile #(.W(WORD_W), .N(REG_CNT)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .ra0   (f_base),
        .ra1   (f_src2),
        .ra2   (f_dst),
        .rd0   (rd_base),
        .rd1   (rd_src2),
        .rd2   (rd_dst)
    );

    mc16_alu #(.W(WORD_W)) u_alu (
        .op (alu_op),
        .a  (s_q.opa),
        .b  (s_q.opb),
        .y  (alu_y)
    );

    always_comb begin
        s_d      = s_q;
        rf_we    = 1'b0;
        rf_waddr = f_dst;
        rf_wdata = '0;
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        if (run_en) begin
            case (s_q.phase)
                PH_FETCH: begin
                    case (s_q.step)
                        2'd0: begin
                            s_d.mar  = s_q.pc;
                            s_d.step = 2'd1;
                        end
                        2'd1: begin
                            mem_rd   = 1'b1;
                            s_d.mdr  = mem_rdata;
                            s_d.step = 2'd2;
                        end
                        default: begin
                            s_d.ir    = s_q.mdr;
                            s_d.pc    = s_q.pc + 1'b1;
                            s_d.step  = 2'd0;
                            s_d.phase = PH_DECODE;
                        end
                    endcase
                end
                PH_DECODE: begin
                    if (is_alu)       s_d.phase = PH_OPND;
                    else if (is_memj) s_d.phase = PH_EVAL;
                    else              s_d.phase = PH_FETCH;
                end
                PH_EVAL: begin
                    if (is_jmp) begin
                        s_d.res   = rd_base + f_off;
                        s_d.phase = PH_STORE;
                    end else begin
                        s_d.mar   = rd_base + f_off;
                        s_d.phase = PH_OPND;
                    end
                end
                PH_OPND: begin
                    if (is_ld) begin
                        mem_rd    = 1'b1;
                        s_d.mdr   = mem_rdata;
                        s_d.phase = PH_STORE;
                    end else if (is_st) begin
                        s_d.mdr   = rd_dst;
                        s_d.phase = PH_STORE;
                    end else begin
                        s_d.opa   = rd_base;
                        s_d.opb   = rd_src2;
                        s_d.phase = PH_EXEC;
                    end
                end
                PH_EXEC: begin
                    s_d.res   = alu_y;
                    s_d.phase = PH_STORE;
                end
                default: begin
                    if (is_st) begin
                        mem_wr = 1'b1;
                    end else if (is_ld) begin
                        rf_we    = 1'b1;
                        rf_wdata = s_q.mdr;
                    end else if (is_jmp) begin
                        s_d.pc = s_q.res;
                        if (do_link) begin
                            rf_we    = 1'b1;
                            rf_waddr = LINK_REG;
                            rf_wdata = s_q.pc;
                        end
                    end else begin
                        rf_we    = 1'b1;
                        rf_wdata = s_q.res;
                    end
                    s_d.phase = PH_FETCH;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_FETCH;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_addr  = s_q.mar;
    assign mem_wdata = s_q.mdr;

    // R11
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> ($stable(s_q.pc) && $stable(s_q.phase) && $stable(s_q.step) && $stable(s_q.ir)));

    // R11
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> (!mem_rd && !mem_wr));

    // R12
    no_rd_wr_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && s_q.phase == PH_FETCH && s_q.step == 2'd2) |=> (s_q.pc == $past(s_q.pc) + 1'b1));

    // R9
    decode_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && s_q.phase == PH_DECODE) |=> (s_q.phase != PH_DECODE));

    // R6
    write_ends_instr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (s_q.phase == PH_FETCH && s_q.step == 2'd0));
endmodule

// File: tb/sim_mc16_core.sv
module sim_mc16_core;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b1;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr;
    logic [15:0] mem [256];

    int tests = 0;
    int fails = 0;
    int cyc_total = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc16_core u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr)
    );

    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        cyc_total <= cyc_total + 1;
        if (cyc_total > WATCHDOG) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected below %0d", cyc_total, WATCHDOG);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic logic [15:0] enc(input logic [3:0] op, input int d, input int b, input int low);
        return {op, 3'(d), 3'(b), 6'(low)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h, expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    // Runs from reset for 80 cycles; reports first write and a few fetch observations.
    task automatic run_prog(input int stall_at, input int stall_len,
                            output int wr_cyc, output logic [15:0] wr_addr,
                            output logic [15:0] wr_data, output int bad_cycles,
                            output logic [15:0] rd1_addr, output logic [15:0] rd8_addr,
                            output logic rd1_seen);
        run_en = 1'b1;
        rst_n  = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        wr_cyc = -1; wr_addr = '0; wr_data = '0; bad_cycles = 0;
        rd1_addr = '1; rd8_addr = '1; rd1_seen = 1'b0;
        for (int c = 1; c <= 80; c++) begin
            @(negedge clk);
            if (mem_rd && mem_wr) bad_cycles++;
            if (!run_en && (mem_rd || mem_wr)) bad_cycles++;
            if (c == 1) begin rd1_seen = mem_rd; rd1_addr = mem_addr; end
            if (c == 8 && mem_rd) rd8_addr = mem_addr;
            if (mem_wr && wr_cyc < 0) begin
                wr_cyc = c; wr_addr = mem_addr; wr_data = mem_wdata;
            end
            if (c == stall_at) run_en = 1'b0;
            if (c == stall_at + stall_len) run_en = 1'b1;
        end
        run_en = 1'b1;
    endtask

    initial begin
        logic [15:0] vals [6];
        logic [3:0]  ops  [3];
        int          wc, bad;
        logic [15:0] wa, wd, r1a, r8a;
        logic        r1s;

        vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF;
        vals[3] = 16'h8000; vals[4] = 16'hFFFF; vals[5] = 16'hA5C3;
        ops[0] = 4'h1; ops[1] = 4'h5; ops[2] = 4'h9;

        // R3, R4, R9, R12: sweep of operations over operand pairs
        for (int o = 0; o < 3; o++) begin
            for (int i = 0; i < 6; i++) begin
                for (int j = 0; j < 6; j++) begin
                    logic [15:0] exp;
                    clear_mem();
                    mem[0] = enc(4'h6, 1, 0, 32);
                    mem[1] = enc(4'h6, 2, 0, 33);
                    mem[2] = enc(ops[o], 3, 1, 2);
                    mem[3] = enc(4'h7, 3, 0, 34);
                    mem[4] = enc(4'hC, 0, 0, 4);
                    mem[32] = vals[i];
                    mem[33] = vals[j];
                    case (o)
                        0: exp = vals[i] + vals[j];
                        1: exp = vals[i] & vals[j];
                        default: exp = ~vals[i];
                    endcase
                    run_prog(0, 0, wc, wa, wd, bad, r1a, r8a, r1s);
                    check(o == 0 ? "R3 add result" : "R4 and/not result", 32'(wd), 32'(exp));
                    check("R9 store strobe cycle", 32'(wc), 32'd27);
                    check("R12 strobe overlap", 32'(bad), 32'd0);
                    if (o == 0 && i == 0 && j == 0) begin
                        check("R1 first read strobe", {31'd0, r1s}, 32'd1);
                        check("R1 first read address", 32'(r1a), 32'd0);
                        check("R2 second fetch address", 32'(r8a), 32'd1);
                        check("R6 store address", 32'(wa), 32'd34);
                    end
                end
            end
        end

        // R5: base plus zero-extended offset, small and maximal offsets
        for (int k = 0; k < 2; k++) begin
            int off;
            off = (k == 0) ? 7 : 63;
            clear_mem();
            mem[0] = enc(4'h6, 4, 0, 40);
            mem[1] = enc(4'h6, 5, 4, off);
            mem[2] = enc(4'h7, 5, 0, 34);
            mem[3] = enc(4'hC, 0, 0, 3);
            mem[40] = 16'd45;
            mem[45 + off] = 16'hBE00 + 16'(off);
            run_prog(0, 0, wc, wa, wd, bad, r1a, r8a, r1s);
            check("R5 load via base+offset", 32'(wd), 32'(16'hBE00 + 16'(off)));
            check("R9 load/store timing", 32'(wc), 32'd20);
        end

        // R6: store with nonzero base
        clear_mem();
        mem[0] = enc(4'h6, 4, 0, 40);
        mem[1] = enc(4'h6, 6, 0, 41);
        mem[2] = enc(4'h7, 6, 4, 50);
        mem[3] = enc(4'hC, 0, 0, 3);
        mem[40] = 16'd60;
        mem[41] = 16'h5A5A;
        run_prog(0, 0, wc, wa, wd, bad, r1a, r8a, r1s);
        check("R6 store address", 32'(wa), 32'd110);
        check("R6 store data", 32'(wd), 32'h5A5A);

        // R7: jump without link leaves R7 at zero
        clear_mem();
        mem[0] = enc(4'hC, 0, 0, 10);
        mem[1] = enc(4'h7, 0, 0, 35);
        mem[10] = enc(4'h7, 7, 0, 34);
        mem[11] = enc(4'hC, 0, 0, 11);
        run_prog(0, 0, wc, wa, wd, bad, r1a, r8a, r1s);
        check("R7 jump target reached", 32'(wa), 32'd34);
        check("R7 no link write", 32'(wd), 32'd0);
        check("R9 jump takes 6 cycles", 32'(wc), 32'd12);

        // R8: jump with link through a nonzero base
        clear_mem();
        mem[0] = enc(4'h6, 3, 0, 40);
        mem[1] = enc(4'hC, 4, 3, 4);
        mem[2] = enc(4'h7, 0, 0, 35);
        mem[20] = enc(4'h7, 7, 0, 34);
        mem[21] = enc(4'hC, 0, 0, 21);
        mem[40] = 16'd16;
        run_prog(0, 0, wc, wa, wd, bad, r1a, r8a, r1s);
        check("R8 link value", 32'(wd), 32'd2);
        check("R8 link jump timing", 32'(wc), 32'd19);

        // R10: unsupported opcodes leave registers and take 4 cycles
        for (int u = 0; u < 16; u++) begin
            if (u == 1 || u == 5 || u == 9 || u == 6 || u == 7 || u == 12) continue;
            clear_mem();
            mem[0] = enc(4'h6, 1, 0, 32);
            mem[1] = enc(4'(u), 1, 1, 1);
            mem[2] = enc(4'h7, 1, 0, 34);
            mem[3] = enc(4'hC, 0, 0, 3);
            mem[32] = 16'h1357;
            run_prog(0, 0, wc, wa, wd, bad, r1a, r8a, r1s);
            check("R10 register untouched", 32'(wd), 32'h1357);
            check("R10 4-cycle skip", 32'(wc), 32'd17);
        end

        // R11: freeze at several points of the same program
        for (int st = 1; st <= 25; st += 6) begin
            clear_mem();
            mem[0] = enc(4'h6, 1, 0, 32);
            mem[1] = enc(4'h6, 2, 0, 33);
            mem[2] = enc(4'h1, 3, 1, 2);
            mem[3] = enc(4'h7, 3, 0, 34);
            mem[4] = enc(4'hC, 0, 0, 4);
            mem[32] = 16'h0F0F;
            mem[33] = 16'h0101;
            run_prog(st, 4, wc, wa, wd, bad, r1a, r8a, r1s);
            check("R11 frozen result", 32'(wd), 32'h1010);
            check("R11 delay equals hold", 32'(wc), 32'd31);
            check("R11 no strobes while frozen", 32'(bad), 32'd0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule